// File: doc/BRIEF.md
# Self-Clearing Converter Control Register

This block is the host-side control register of a serial converter interface. A write port delivers a 14-bit data word together with a 2-bit register address. The block stores the word only when the address selects it. The register cannot be read back. Its contents are offered as decoded control outputs: power management, read-register selection, interface mode, conversion start, calibration kind, calibration selection and calibration start.

Three bits clear themselves on internal events, each on its own strobe. The interface-mode bit clears when a read cycle completes. The conversion-start bit clears at end of conversion. The calibration-start bit clears at end of calibration. Setting either start bit also gives a one-cycle start pulse. The bit then remains high as a busy indication until its strobe arrives.

The 2-bit calibration-select field has two meanings. While calibration is running it names the calibration type. While calibration is idle it addresses a coefficient register. A registered decode of the power-management field and the external sleep request gives a 2-bit power-down mode code.

Top module: `adc_ctrl_reg`

## Requirements
- R1: After synchronous reset every output is 0: fields, busy flags, pulses, `wr_illegal_o`, `cal_type_o` and `pd_mode_o`. The one exception is `coef_sel_vld_o`, which is 1 because calibration is idle.
- R2: A write is accepted only when `wr_en_i` is 1 and `wr_addr_i` is 2'b11. Any other address leaves every output unchanged.
- R3: An accepted write with any of data bits 13..10 set raises `wr_illegal_o` for exactly the next cycle. The other bits of that write still take effect.
- R4: An accepted write loads `pwr_field_o` from bits 9..8, `rd_sel_o` from bits 7..6, `cal_system_o` from bit 3 and `cal_sel_o` from bits 2..1. The new values are visible in the cycle after the write edge.
- R5: `if_mode1_o` takes bit 5 on an accepted write. When it is not being written, `rd_done_i` forces it to 0. A same-cycle write of 1 overrides the clear.
- R6: An accepted write with bit 4 set raises `conv_start_o` for exactly one cycle and sets `conv_busy_o`. `conv_busy_o` stays 1 until `eoc_i` arrives. A later write with bit 4 at 0 does not clear it.
- R7: If `eoc_i` arrives in the same cycle as an accepted write with bit 4 set, the write wins and `conv_busy_o` is 1.
- R8: Bit 0 and `eoc_cal_i` drive `cal_start_o` and `cal_busy_o` under the same rules as R6 and R7, write wins included.
- R9: While `cal_busy_o` is 1, `cal_type_o` equals {bit 3, bits 2..1} of the stored word, and `coef_sel_vld_o` is 0. While calibration is idle, `cal_type_o` is 0, `coef_sel_vld_o` is 1, and `cal_sel_o` is the coefficient register address.
- R10: `pd_mode_o` is registered one cycle behind the stored power field and `sleep_i`. The codes are:
  - field 00 with `sleep_i` at 0 gives 00 (powered);
  - field 00 with `sleep_i` at 1 gives 11 (pin power-down);
  - field 01 gives 00;
  - field 10 gives 01 (full power-down);
  - field 11 gives 10 (partial power-down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe from the serial shifter |
| wr_addr_i | input | 2 | Register address of the write |
| wr_data_i | input | 14 | Write data word |
| sleep_i | input | 1 | External sleep request |
| rd_done_i | input | 1 | Read cycle completed strobe |
| eoc_i | input | 1 | End-of-conversion strobe |
| eoc_cal_i | input | 1 | End-of-calibration strobe |
| pwr_field_o | output | 2 | Stored power-management field |
| rd_sel_o | output | 2 | Stored read-register select |
| if_mode1_o | output | 1 | Interface mode 1 (data line bidirectional) |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| conv_busy_o | output | 1 | Conversion-start bit, high until end of conversion |
| cal_system_o | output | 1 | Calibration kind, 1 = system, 0 = self |
| cal_sel_o | output | 2 | Stored calibration-select field |
| cal_start_o | output | 1 | One-cycle calibration start pulse |
| cal_busy_o | output | 1 | Calibration-start bit, high until end of calibration |
| cal_type_o | output | 3 | Running calibration type, 0 when idle |
| coef_sel_vld_o | output | 1 | Select field currently addresses a coefficient register |
| wr_illegal_o | output | 1 | Pulse: last accepted write had reserved bits set |
| pd_mode_o | output | 2 | Registered power-down mode code |

## Verification
The assertions assume that the strobes `rd_done_i`, `eoc_i` and `eoc_cal_i` are synchronous single-cycle inputs. They also assume that write inputs are stable around the clock edge. They do not assume that the strobes are mutually exclusive or that they follow a start. The stimulus drives every input half a cycle away from the sampling edge. It fires strobes at random, including while nothing is busy and in the same cycle as a setting write. About half of the writes carry the selecting address. A small share of accepted writes set reserved bits, so both legal and flagged words are covered.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int CTRL_W  = 14;
    localparam int ADDR_W  = 2;
    localparam int RSV_LSB = 10;

    // bit positions the decode depends on
    localparam int B_PWR   = 8;
    localparam int B_RDSEL = 6;
    localparam int B_IFM   = 5;
    localparam int B_CONV  = 4;
    localparam int B_CALMD = 3;
    localparam int B_CSEL  = 1;
    localparam int B_CALST = 0;

    typedef struct packed {
        logic [1:0] pwr;
        logic [1:0] rdsel;
        logic       ifm;
        logic       conv;
        logic       calmd;
        logic [1:0] calsel;
        logic       calst;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        PD_ON      = 2'b00,
        PD_FULL    = 2'b01,
        PD_PARTIAL = 2'b10,
        PD_PIN     = 2'b11
    } pd_mode_e;

    function automatic ctrl_word_t unpack_word(input logic [CTRL_W-1:0] d);
        ctrl_word_t w;
        w.pwr    = d[B_PWR+:2];
        w.rdsel  = d[B_RDSEL+:2];
        w.ifm    = d[B_IFM];
        w.conv   = d[B_CONV];
        w.calmd  = d[B_CALMD];
        w.calsel = d[B_CSEL+:2];
        w.calst  = d[B_CALST];
        return w;
    endfunction

    function automatic pd_mode_e pd_decode(input logic [1:0] fld, input logic sleep);
        pd_mode_e m;
        case (fld)
            2'b00:   m = sleep ? PD_PIN : PD_ON;
            2'b01:   m = PD_ON;
            2'b10:   m = PD_FULL;
            default: m = PD_PARTIAL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/adc_ctrl_wr_dec.sv
module adc_ctrl_wr_dec
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W  = CTRL_W,
    parameter int AW      = ADDR_W,
    parameter int RSV_POS = RSV_LSB
) (
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              accept,
    output logic              illegal,
    output ctrl_word_t        word
);
    localparam logic [AW-1:0] SEL_ADDR = {AW{1'b1}};
    localparam int            RSV_W    = DATA_W - RSV_POS;

    assign accept  = wr_en && (wr_addr == SEL_ADDR);
    assign illegal = accept && (|wr_data[DATA_W-1:RSV_POS]);
    // reserved bits never reach storage
    assign word    = unpack_word({{RSV_W{1'b0}}, wr_data[RSV_POS-1:0]});
endmodule

// File: rtl/adc_ctrl_selfclr.sv
module adc_ctrl_selfclr (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic busy_o,
    output logic pulse_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o  <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= set_i;
            if (set_i)
                busy_o <= 1'b1;      // set beats a same-cycle clear
            else if (clr_i)
                busy_o <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_ctrl_pd.sv
module adc_ctrl_pd
    import adc_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] fld_i,
    input  logic       sleep_i,
    output pd_mode_e   mode_o
);
    always_ff @(posedge clk) begin
        if (rst) mode_o <= PD_ON;
        else     mode_o <= pd_decode(fld_i, sleep_i);
    end
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W  = CTRL_W,
    parameter int AW      = ADDR_W,
    parameter int RSV_POS = RSV_LSB,
    parameter int N_START = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              sleep_i,
    input  logic              rd_done_i,
    input  logic              eoc_i,
    input  logic              eoc_cal_i,
    output logic [1:0]        pwr_field_o,
    output logic [1:0]        rd_sel_o,
    output logic              if_mode1_o,
    output logic              conv_start_o,
    output logic              conv_busy_o,
    output logic              cal_system_o,
    output logic [1:0]        cal_sel_o,
    output logic              cal_start_o,
    output logic              cal_busy_o,
    output logic [2:0]        cal_type_o,
    output logic              coef_sel_vld_o,
    output logic              wr_illegal_o,
    output logic [1:0]        pd_mode_o
);
    localparam int SI_CONV = 0;
    localparam int SI_CAL  = 1;

    logic       acc, illegal;
    ctrl_word_t w;
    ctrl_word_t st;
    pd_mode_e   pdm;

    logic [N_START-1:0] s_set, s_clr, s_busy, s_pulse;

    adc_ctrl_wr_dec #(.DATA_W(DATA_W), .AW(AW), .RSV_POS(RSV_POS)) i_dec (
        .wr_en   (wr_en_i),
        .wr_addr (wr_addr_i),
        .wr_data (wr_data_i),
        .accept  (acc),
        .illegal (illegal),
        .word    (w)
    );

    // static fields and interface mode
    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= '0;
            wr_illegal_o <= 1'b0;
        end else begin
            wr_illegal_o <= illegal;
            if (acc) begin
                st.pwr    <= w.pwr;
                st.rdsel  <= w.rdsel;
                st.calmd  <= w.calmd;
                st.calsel <= w.calsel;
                st.ifm    <= w.ifm;
            end else if (rd_done_i) begin
                st.ifm    <= 1'b0;
            end
        end
    end

    assign s_set[SI_CONV] = acc && w.conv;
    assign s_clr[SI_CONV] = eoc_i;
    assign s_set[SI_CAL]  = acc && w.calst;
    assign s_clr[SI_CAL]  = eoc_cal_i;

    for (genvar g = 0; g < N_START; g++) begin : g_start
        adc_ctrl_selfclr i_bit (
            .clk     (clk),
            .rst     (rst),
            .set_i   (s_set[g]),
            .clr_i   (s_clr[g]),
            .busy_o  (s_busy[g]),
            .pulse_o (s_pulse[g])
        );
    end

    adc_ctrl_pd i_pd (
        .clk     (clk),
        .rst     (rst),
        .fld_i   (st.pwr),
        .sleep_i (sleep_i),
        .mode_o  (pdm)
    );

    assign pwr_field_o    = st.pwr;
    assign rd_sel_o       = st.rdsel;
    assign if_mode1_o     = st.ifm;
    assign cal_system_o   = st.calmd;
    assign cal_sel_o      = st.calsel;
    assign conv_busy_o    = s_busy[SI_CONV];
    assign conv_start_o   = s_pulse[SI_CONV];
    assign cal_busy_o     = s_busy[SI_CAL];
    assign cal_start_o    = s_pulse[SI_CAL];
    assign cal_type_o     = s_busy[SI_CAL] ? {st.calmd, st.calsel} : 3'b000;
    assign coef_sel_vld_o = !s_busy[SI_CAL];
    assign pd_mode_o      = pdm;
endmodule

// File: rtl/adc_ctrl_reg_chk.sv
module adc_ctrl_reg_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en_i,
    input logic [1:0]  wr_addr_i,
    input logic [13:0] wr_data_i,
    input logic        rd_done_i,
    input logic        eoc_i,
    input logic        eoc_cal_i,
    input logic [1:0]  pwr_field_o,
    input logic [1:0]  rd_sel_o,
    input logic        if_mode1_o,
    input logic        conv_start_o,
    input logic        conv_busy_o,
    input logic        cal_start_o,
    input logic        cal_busy_o,
    input logic        wr_illegal_o,
    input logic [1:0]  pd_mode_o
);
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == 2'b11);

    // R2
    no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(rd_sel_o) && $stable(pwr_field_o));

    // R3
    illegal_src_chk: assert property (@(posedge clk) disable iff (rst)
        wr_illegal_o |-> $past(hit && (|wr_data_i[13:10])));

    // R5
    ifm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_done_i && !hit) |=> !if_mode1_o);

    // R6
    conv_pulse_busy_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> conv_busy_o);

    // R6
    conv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_busy_o && !eoc_i) |=> conv_busy_o);

    // R7
    conv_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && wr_data_i[4]) |=> conv_busy_o && conv_start_o);

    // R8
    cal_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (eoc_cal_i && !(hit && wr_data_i[0])) |=> !cal_busy_o && !cal_start_o);

    // R10
    pd_full_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_field_o == 2'b10) |=> (pd_mode_o == 2'b01));
endmodule

bind adc_ctrl_reg adc_ctrl_reg_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .rd_done_i    (rd_done_i),
    .eoc_i        (eoc_i),
    .eoc_cal_i    (eoc_cal_i),
    .pwr_field_o  (pwr_field_o),
    .rd_sel_o     (rd_sel_o),
    .if_mode1_o   (if_mode1_o),
    .conv_start_o (conv_start_o),
    .conv_busy_o  (conv_busy_o),
    .cal_start_o  (cal_start_o),
    .cal_busy_o   (cal_busy_o),
    .wr_illegal_o (wr_illegal_o),
    .pd_mode_o    (pd_mode_o)
);

// File: tb/test_adc_ctrl_reg.sv
`timescale 1ns/1ps
module test_adc_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'b00;
    logic [13:0] wr_data = '0;
    logic        sleep = 1'b0, rd_done = 1'b0, eoc = 1'b0, eoc_cal = 1'b0;
    logic [1:0]  pwr_o, rdsel_o, pd_o, csel_o;
    logic        ifm_o, cst_o, cbusy_o, calsys_o, kst_o, kbusy_o, cvld_o, ill_o;
    logic [2:0]  ctype_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    adc_ctrl_reg i_adc_ctrl_reg (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .sleep_i(sleep), .rd_done_i(rd_done),
        .eoc_i(eoc), .eoc_cal_i(eoc_cal), .pwr_field_o(pwr_o),
        .rd_sel_o(rdsel_o), .if_mode1_o(ifm_o), .conv_start_o(cst_o),
        .conv_busy_o(cbusy_o), .cal_system_o(calsys_o), .cal_sel_o(csel_o),
        .cal_start_o(kst_o), .cal_busy_o(kbusy_o), .cal_type_o(ctype_o),
        .coef_sel_vld_o(cvld_o), .wr_illegal_o(ill_o), .pd_mode_o(pd_o)
    );

    // reference state
    logic [1:0] m_pwr, m_rdsel, m_csel, m_pd;
    logic       m_ifm, m_cst, m_cb, m_md, m_kst, m_kb, m_ill;

    function automatic logic [1:0] exp_pd(input logic [1:0] f, input logic s);
        if (f == 2'b00) return s ? 2'b11 : 2'b00;
        if (f == 2'b01) return 2'b00;
        if (f == 2'b10) return 2'b01;
        return 2'b10;
    endfunction

    task automatic model_reset();
        m_pwr = 0; m_rdsel = 0; m_csel = 0; m_pd = 0;
        m_ifm = 0; m_cst = 0; m_cb = 0; m_md = 0; m_kst = 0; m_kb = 0; m_ill = 0;
    endtask

    task automatic model_step();
        logic acc;
        acc   = wr_en && (wr_addr == 2'b11);
        m_pd  = exp_pd(m_pwr, sleep);
        m_ill = acc && (|wr_data[13:10]);
        m_cst = acc && wr_data[4];
        m_cb  = m_cst ? 1'b1 : (eoc ? 1'b0 : m_cb);
        m_kst = acc && wr_data[0];
        m_kb  = m_kst ? 1'b1 : (eoc_cal ? 1'b0 : m_kb);
        if (acc) begin
            m_pwr = wr_data[9:8]; m_rdsel = wr_data[7:6]; m_ifm = wr_data[5];
            m_md = wr_data[3]; m_csel = wr_data[2:1];
        end else if (rd_done) begin
            m_ifm = 1'b0;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R4", "pwr_field", pwr_o, m_pwr);
        chk("R4", "rd_sel", rdsel_o, m_rdsel);
        chk("R4", "cal_system", calsys_o, m_md);
        chk("R4", "cal_sel", csel_o, m_csel);
        chk("R5", "if_mode1", ifm_o, m_ifm);
        chk("R6", "conv_start", cst_o, m_cst);
        chk("R6", "conv_busy", cbusy_o, m_cb);
        chk("R8", "cal_start", kst_o, m_kst);
        chk("R8", "cal_busy", kbusy_o, m_kb);
        chk("R9", "cal_type", ctype_o, m_kb ? {m_md, m_csel} : 3'd0);
        chk("R9", "coef_sel_vld", cvld_o, !m_kb);
        chk("R3", "wr_illegal", ill_o, m_ill);
        chk("R10", "pd_mode", pd_o, m_pd);
    endtask

    // inputs set at negedge; model follows the edge; compare at next negedge
    task automatic tick(input logic we, input logic [1:0] a, input logic [13:0] d,
                        input logic sl, input logic rdd, input logic ec, input logic ek);
        wr_en = we; wr_addr = a; wr_data = d; sleep = sl;
        rd_done = rdd; eoc = ec; eoc_cal = ek;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "conv_busy after reset", cbusy_o, 0);
        chk("R1", "coef_sel_vld after reset", cvld_o, 1);
        chk("R1", "pd_mode after reset", pd_o, 0);
        check_all();

        // R2 wrong address ignored
        tick(1, 2'b10, 14'h03FF, 0, 0, 0, 0);
        chk("R2", "rd_sel after other address", rdsel_o, 0);
        // R4 field load, R6 conversion start, R3 illegal bits
        tick(1, 2'b11, 14'h2000 | 14'h0155, 0, 0, 0, 0);
        chk("R3", "illegal pulse", ill_o, 1);
        chk("R6", "conv pulse", cst_o, 1);
        tick(0, 2'b11, 0, 0, 0, 0, 0);
        chk("R6", "pulse one cycle", cst_o, 0);
        // R6 writing 0 keeps busy
        tick(1, 2'b11, 14'h0000, 0, 0, 0, 0);
        chk("R6", "busy kept by zero write", cbusy_o, 1);
        // R7 eoc with setting write
        tick(1, 2'b11, 14'h0010, 0, 0, 1, 0);
        chk("R7", "write wins over eoc", cbusy_o, 1);
        tick(0, 2'b00, 0, 0, 0, 1, 0);
        chk("R6", "eoc clears busy", cbusy_o, 0);
        // R8 calibration start, R9 type while busy
        tick(1, 2'b11, 14'h000F, 0, 0, 0, 1);
        chk("R8", "cal write wins", kbusy_o, 1);
        chk("R9", "cal_type system gain", ctype_o, 3'b111);
        tick(0, 2'b00, 0, 0, 0, 0, 1);
        chk("R9", "coef addressing after end", cvld_o, 1);
        // R5 interface mode vs read done
        tick(1, 2'b11, 14'h0020, 0, 1, 0, 0);
        chk("R5", "write of 1 beats read done", ifm_o, 1);
        tick(0, 2'b00, 0, 0, 1, 0, 0);
        chk("R5", "read done clears", ifm_o, 0);
        // R10 sleep pin with field 00
        tick(0, 2'b00, 0, 1, 0, 0, 0);
        chk("R10", "pin power-down", pd_o, 2'b11);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [13:0] d;
            d = 14'($urandom);
            if (($urandom % 8) != 0) d[13:10] = 4'b0;
            tick(($urandom % 4) != 0, (($urandom % 2) == 0) ? 2'b11 : 2'($urandom),
                 d, 1'($urandom), ($urandom % 5) == 0, ($urandom % 6) == 0,
                 ($urandom % 6) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule